// File: doc/BRIEF.md
# Gated Time-Stamp Clock and Counter

This block produces the time-stamp tick that is shared by every readout system in an event-building setup, and keeps a 64-bit time-stamp count driven by that tick. The tick comes either from a divider on the system clock (divide by 4, so a 40 MHz clock gives a 10 MHz tick) or from an external tick input. A run-enable input (`go`) stops the tick completely while it is low. During that idle period a clear strobe may zero the counter. Raising `go` then releases the tick with the divider phase set to a known value, so all counters fed from the distributed tick start together.

A capture event copies the whole count into a capture register. The event is either the internal trigger strobe or a rising edge on the external latch input, chosen by a select bit. The captured value is read back as four 16-bit words through a small read port that is addressed combinationally. The gated tick and the capture event are both driven out as one-cycle pulses, so that other time-stamp modules can be slaved to this one.

Both external inputs are asynchronous. Each passes through a two-flop synchronizer followed by a rising-edge detector before it is used.

Top module: `tstamp_gen`

## Requirements
- R1: With `src_sel[0]`=0 and `go` high, a tick occurs every DIV clock cycles. After `go` rises, the first tick occurs on the DIV-th rising clock edge at which `go` is sampled high.
- R2: With `src_sel[0]`=1, each rising edge of `ext_tick` produces exactly one tick. `tick_out` goes high after the third rising clock edge that follows the input change: two synchronizer flops, then the output register.
- R3: While `go` is low, no tick occurs, `tick_out` stays 0 and the counter holds its value.
- R4: A `cnt_clr` pulse sampled while `go` is low zeroes the counter. A `cnt_clr` pulse sampled while `go` is high is ignored.
- R5: The 64-bit counter increments by exactly one per tick and carries across all 64 bits.
- R6: With `src_sel[1]`=0, a `trig` pulse is the capture event and `ext_latch` is ignored. With `src_sel[1]`=1, a synchronized rising edge of `ext_latch` is the capture event and `trig` is ignored. On a capture event, all 64 bits of the pre-increment count are copied into the capture register on the same edge.
- R7: `rd_data` is combinational. Address 1 returns capture bits 15:0, address 2 returns bits 31:16, address 3 returns bits 47:32 and address 4 returns bits 63:48. Addresses 0, 5, 6 and 7 return 0.
- R8: `tick_out` and `latch_out` are each a one-cycle pulse. Each is high in the cycle after the clock edge at which the counter stepped or the capture was taken.
- R9: After reset, the counter, the capture register, `tick_out` and `latch_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Run enable; gates the tick |
| src_sel | input | 2 | Bit 0: external tick source; bit 1: external latch source |
| ext_tick | input | 1 | Asynchronous external tick |
| ext_latch | input | 1 | Asynchronous external capture request |
| trig | input | 1 | Internal trigger capture strobe (synchronous) |
| cnt_clr | input | 1 | Counter clear strobe; honoured only while go is low |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 16 | Selected 16-bit slice of the capture register |
| tick_out | output | 1 | Gated tick pulse for distribution |
| latch_out | output | 1 | Capture pulse for distribution |

## Verification
The bound assertions check the following on every cycle:
- the counter never moves while `go` is low, except for a clear to zero;
- the counter never steps by more than one;
- a clear arriving while `go` is high leaves the count untouched;
- each `tick_out` pulse matches a one-step increment;
- each `latch_out` pulse matches a capture of the count from the previous cycle;
- the divider phase is zero whenever `go` rises.

The bench's scenarios are needed for the behaviour the assertions cannot see:
- the exact tick spacing and the synchronizer latency on the external inputs;
- the choice between capture sources;
- the address decode of the read words;
- a carry from the lowest 16-bit word into the next one.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int SEL_EXT_TICK  = 0;
  localparam int SEL_EXT_LATCH = 1;

  function automatic int wrap_inc(input int cur, input int modulus);
    return (cur >= modulus - 1) ? 0 : cur + 1;
  endfunction

  function automatic bit addr_hits_word(input int addr, input int word_idx);
    return addr == word_idx + 1;
  endfunction
endpackage

// File: rtl/tsc_sync_edge.sv
module tsc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] shreg;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      last_q <= 1'b0;
    end else begin
      shreg  <= {shreg[STAGES-2:0], din};
      last_q <= shreg[STAGES-1];
    end
  end

  assign rise = shreg[STAGES-1] & ~last_q;
endmodule

// File: rtl/tsc_tick_gen.sv
module tsc_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic use_ext,
  input  logic ext_rise,
  output logic tick,
  output logic at_zero
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !go) begin
      phase_q <= '0;
    end else begin
      phase_q <= PH_W'(tsc_pkg::wrap_inc(int'(phase_q), DIV));
    end
  end

  assign at_zero = (phase_q == '0);
  assign tick    = go & (use_ext ? ext_rise : (phase_q == LAST));
endmodule

// File: rtl/tsc_count.sv
module tsc_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             clr,
  input  logic             tick,
  input  logic             cap_ev,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      capture <= '0;
    end else begin
      if (cap_ev) capture <= count;
      if (!go && clr)  count <= '0;
      else if (tick)   count <= count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tstamp_gen.sv
module tstamp_gen #(
  parameter int DIV     = 4,
  parameter int CNT_W   = 64,
  parameter int WORD_W  = 16,
  parameter int ADDR_W  = 3,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [1:0]        src_sel,
  input  logic              ext_tick,
  input  logic              ext_latch,
  input  logic              trig,
  input  logic              cnt_clr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              tick_out,
  output logic              latch_out
);
  localparam int NWORDS = CNT_W / WORD_W;

  logic [1:0]       raw_in;
  logic [1:0]       in_rise;
  logic             tick_gated;
  logic             phase_zero;
  logic             latch_ev;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] capture_q;

  assign raw_in = {ext_latch, ext_tick};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    tsc_sync_edge #(.STAGES(SYNC_ST)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in[g]),
      .rise (in_rise[g])
    );
  end

  tsc_tick_gen #(.DIV(DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .use_ext (src_sel[tsc_pkg::SEL_EXT_TICK]),
    .ext_rise(in_rise[0]),
    .tick    (tick_gated),
    .at_zero (phase_zero)
  );

  assign latch_ev = src_sel[tsc_pkg::SEL_EXT_LATCH] ? in_rise[1] : trig;

  tsc_count #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .clr    (cnt_clr),
    .tick   (tick_gated),
    .cap_ev (latch_ev),
    .count  (count_q),
    .capture(capture_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_out  <= 1'b0;
      latch_out <= 1'b0;
    end else begin
      tick_out  <= tick_gated;
      latch_out <= latch_ev;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NWORDS; i++) begin
      if (tsc_pkg::addr_hits_word(int'(rd_addr), i))
        rd_data = capture_q[i*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/tsc_checks.sv
module tsc_checks #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             cnt_clr,
  input logic             tick,
  input logic             phase_zero,
  input logic             tick_out,
  input logic             latch_out,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] capture
);
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !cnt_clr) |=> $stable(count));

  p_clr_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && cnt_clr) |=> (count == '0));

  p_clr_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cnt_clr && !tick) |=> $stable(count));

  p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> ((count == $past(count)) || (count == $past(count) + CNT_W'(1))));

  p_tick_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> (count == $past(count) + CNT_W'(1)));

  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    latch_out |-> (capture == $past(count)));

  p_phase_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go) |-> phase_zero);
endmodule

bind tstamp_gen tsc_checks #(.CNT_W(CNT_W)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .go        (go),
  .cnt_clr   (cnt_clr),
  .tick      (tick_gated),
  .phase_zero(phase_zero),
  .tick_out  (tick_out),
  .latch_out (latch_out),
  .count     (count_q),
  .capture   (capture_q)
);

// File: tb/sim_tstamp_gen.sv
`timescale 1ns/1ps
module sim_tstamp_gen;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [1:0]  src_sel = 2'b00;
  logic        ext_tick = 1'b0, ext_latch = 1'b0, trig = 1'b0, cnt_clr = 1'b0;
  logic [2:0]  rd_addr = 3'd0;
  logic [15:0] rd_data;
  logic        tick_out, latch_out;

  logic        go1 = 1'b0, trig1 = 1'b0, clr1 = 1'b0;
  logic [2:0]  addr1 = 3'd0;
  logic [15:0] data1;
  logic        tick1, latch1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  tstamp_gen #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .src_sel(src_sel),
    .ext_tick(ext_tick), .ext_latch(ext_latch), .trig(trig), .cnt_clr(cnt_clr),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick_out(tick_out), .latch_out(latch_out)
  );

  tstamp_gen #(.DIV(1)) u1 (
    .clk(clk), .rst_n(rst_n), .go(go1), .src_sel(2'b00),
    .ext_tick(1'b0), .ext_latch(1'b0), .trig(trig1), .cnt_clr(clr1),
    .rd_addr(addr1), .rd_data(data1), .tick_out(tick1), .latch_out(latch1)
  );

  // behavioural reference for u0
  bit          hist_t[$];
  bit          hist_l[$];
  int          m_phase;
  logic [63:0] m_cnt, m_cap;
  bit          m_tick, m_latch;

  always @(posedge clk) begin
    bit tk, lev, et, el;
    if (!rst_n) begin
      hist_t = '{0, 0, 0};
      hist_l = '{0, 0, 0};
      m_phase = 0; m_cnt = 0; m_cap = 0; m_tick = 0; m_latch = 0;
    end else begin
      et  = hist_t[1] && !hist_t[2];
      el  = hist_l[1] && !hist_l[2];
      tk  = go && (src_sel[0] ? et : (m_phase == DIV - 1));
      lev = src_sel[1] ? el : trig;
      if (lev) m_cap = m_cnt;
      if (!go && cnt_clr) m_cnt = 0;
      else if (tk) m_cnt = m_cnt + 1;
      m_phase = go ? ((m_phase + 1) % DIV) : 0;
      m_tick = tk;
      m_latch = lev;
      hist_t.push_front(ext_tick); void'(hist_t.pop_back());
      hist_l.push_front(ext_latch); void'(hist_l.pop_back());
    end
  end

  function automatic logic [15:0] exp_word(logic [63:0] v, logic [2:0] a);
    if (a >= 3'd1 && a <= 3'd4) return 16'(v >> (16 * (int'(a) - 1)));
    return 16'h0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R8 tick_out", {63'd0, tick_out}, {63'd0, m_tick});
      chk("R8 latch_out", {63'd0, latch_out}, {63'd0, m_latch});
      chk("R7 rd_data", {48'd0, rd_data}, {48'd0, exp_word(m_cap, rd_addr)});
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig;
    trig = 1'b1; step(1); trig = 1'b0; step(1);
  endtask

  task automatic read_all(input string tag, input logic [63:0] exp);
    for (int a = 1; a <= 4; a++) begin
      rd_addr = 3'(a);
      #1;
      chk(tag, {48'd0, rd_data}, {48'd0, exp[16*(a-1) +: 16]});
    end
    rd_addr = 3'd0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    logic [63:0] snap;
    step(3);
    // R9: reset state
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a); #1;
      chk("R9 reset rd_data", {48'd0, rd_data}, 64'd0);
    end
    rd_addr = 3'd0;
    chk("R9 reset tick_out", {63'd0, tick_out}, 64'd0);
    rst_n = 1'b1;
    step(2);

    // R1: first tick on the 4th edge after go rises, then every 4
    go = 1'b1;
    step(3);
    chk("R1 no tick before DIV edges", {63'd0, tick_out}, 64'd0);
    step(1);
    chk("R1 first tick", {63'd0, tick_out}, 64'd1);
    step(3);
    chk("R1 gap", {63'd0, tick_out}, 64'd0);
    step(1);
    chk("R1 second tick", {63'd0, tick_out}, 64'd1);
    step(32);
    pulse_trig;
    read_all("R1 R6 count after 40 cycles", m_cap);
    chk("R1 tick count", m_cap, 64'd10);

    // R3: go low suppresses ticks and holds the count
    go = 1'b0;
    step(1);
    snap = m_cnt;
    for (int i = 0; i < 20; i++) begin
      step(1);
      chk("R3 tick suppressed", {63'd0, tick_out}, 64'd0);
    end
    pulse_trig;
    read_all("R3 count held", snap);

    // R4: clear ignored while go high
    go = 1'b1; step(9);
    cnt_clr = 1'b1; step(1); cnt_clr = 1'b0;
    pulse_trig;
    chk("R4 clear ignored nonzero", {63'd0, (m_cap != 0)}, 64'd1);
    read_all("R4 clear ignored", m_cap);
    // R4: clear honoured while go low
    go = 1'b0; step(1);
    cnt_clr = 1'b1; step(1); cnt_clr = 1'b0;
    pulse_trig;
    read_all("R4 cleared", 64'd0);

    // R2: external tick, latency and one tick per edge
    src_sel = 2'b01; go = 1'b1; step(2);
    ext_tick = 1'b1;
    step(2);
    chk("R2 latency not yet", {63'd0, tick_out}, 64'd0);
    step(1);
    chk("R2 latency third edge", {63'd0, tick_out}, 64'd1);
    step(1);
    chk("R2 single pulse", {63'd0, tick_out}, 64'd0);
    ext_tick = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step(3); ext_tick = 1'b1; step(4 + i); ext_tick = 1'b0;
    end
    step(5);
    pulse_trig;
    chk("R2 five external edges", m_cap, 64'd5);
    read_all("R2 read", 64'd5);

    // R6: external latch source, trig ignored
    src_sel = 2'b11;
    trig = 1'b1; step(1); trig = 1'b0;
    chk("R6 trig ignored", {63'd0, latch_out}, 64'd0);
    ext_tick = 1'b1; step(4); ext_tick = 1'b0; step(4);
    ext_latch = 1'b1;
    step(2);
    chk("R6 latch not yet", {63'd0, latch_out}, 64'd0);
    step(1);
    chk("R6 external latch", {63'd0, latch_out}, 64'd1);
    read_all("R6 captured", 64'd6);
    ext_latch = 1'b0;
    step(4);
    // R6: ext_latch ignored when internal source selected
    src_sel = 2'b00;
    ext_latch = 1'b1; step(4);
    chk("R6 ext latch ignored", {63'd0, latch_out}, 64'd0);
    ext_latch = 1'b0;
    go = 1'b0;
    // R7: unmapped addresses
    for (int a = 5; a < 8; a++) begin
      rd_addr = 3'(a); #1;
      chk("R7 unmapped address", {48'd0, rd_data}, 64'd0);
    end
    rd_addr = 3'd0;

    // R5: carry into the second word (u1 ticks every cycle)
    step(1);
    go1 = 1'b1;
    step(65540);
    go1 = 1'b0;
    trig1 = 1'b1; step(1); trig1 = 1'b0; step(1);
    addr1 = 3'd1; #1; chk("R5 carry word1", {48'd0, data1}, 64'h4);
    addr1 = 3'd2; #1; chk("R5 carry word2", {48'd0, data1}, 64'h1);
    addr1 = 3'd3; #1; chk("R5 carry word3", {48'd0, data1}, 64'h0);
    step(2);
    finish_run;
  end

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run;
  end
endmodule